// File: doc/BRIEF.md
# Soft-Decision Frame Viterbi Decoder

This block decodes one frame of a rate 1/2, constraint-length 7 convolutional code. It receives pairs of 8-bit soft symbols and returns the decoded user bits packed into bytes. Each soft symbol runs from 0 (certain zero) to 255 (certain one). An array of 64 add-compare-select cells updates one path metric per encoder state for every symbol pair. Each step writes one survivor decision bit per state into a decision memory.

A frame opens with a one-cycle `start`. At that edge the user length, the encoder start state, the forced terminal state and the symbol convention are taken from the ports. The decoder then accepts the user bits plus six tail bits' worth of symbol pairs. After the last pair it walks the survivors backwards from the terminal state into a bit buffer. It then streams the user bytes out first byte first and pulses `done`. The generator taps are parameters. The defaults are 7'b1101101 for the first symbol and 7'b1001111 for the second.

The encoder state is the last six input bits, with the newest bit in bit 0. The expected symbol for each tap is the parity of {old state, new bit} masked with that tap.

Top module: `vit_decoder`

## Requirements
- R1: Symbols 0 and 255 stand for a certain 0 and a certain 1. A frame sent with clean symbols (expected bit 0 sent as 0, expected bit 1 sent as 255) decodes to exactly the encoded user bits.
- R2: `sym_ready` is low after reset and outside a frame. A frame of `len` user bits accepts exactly `len`+6 symbol pairs, and `sym_ready` is low in the cycle after the last pair.
- R3: At `start` the metric of `start_state` is set to zero and every other state starts at INIT_BIAS. A frame encoded from a non-zero start state decodes correctly.
- R4: Traceback starts at `end_state` on the last tail step. The six tail bits are not output, so exactly ceil(`len`/8) bytes come out.
- R5: Bytes are MSB first: user bit 0 is bit 7 of the first byte. Bit positions past `len` in the last byte are 0.
- R6: Convention control `conv`: bit 0 inverts the expected bit of the first tap, and bit 1 inverts the expected bit of the second tap. With bit 2 = 0 the first tap's symbol is in `sym_pair[7:0]`; with bit 2 = 1 it is in `sym_pair[15:8]`.
- R7: A `start` with `len` = 0 or `len` > MAX_BITS raises `err` for one cycle. No symbol is accepted and no byte or `done` follows.
- R8: Path metrics are PM_W bits wide. When the smallest metric is at least RENORM_TH, that minimum is subtracted from every metric in the same update. Decoding results are unchanged and metrics never approach overflow.
- R9: `done` is high for one cycle, in the cycle right after the last `out_valid` byte. `done` and `out_valid` are never high together.
- R10: A `start` while a frame is in progress is ignored, and the frame completes with its original parameters.
- R11: Isolated symbol errors (a single fully inverted symbol, at least ten steps from any other) are corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a frame when idle |
| len | input | LEN_W | User bits in the frame, tail excluded |
| start_state | input | 6 | Encoder state at frame start |
| end_state | input | 6 | Encoder state forced by the tail |
| conv | input | 3 | Inversion and order convention |
| sym_valid | input | 1 | Symbol pair offered |
| sym_pair | input | 16 | Two soft symbols |
| sym_ready | output | 1 | Decoder accepts a pair |
| out_valid | output | 1 | Decoded byte valid |
| out_byte | output | 8 | Decoded byte, MSB first |
| done | output | 1 | Frame finished pulse |
| err | output | 1 | Frame rejected pulse |

## Verification
Metric renormalisation and the add-compare-select decision can fall in the same update. On such a step the surviving candidate and its subtraction of the old minimum both act on one edge. The bench provokes this with frames of weak symbols (64 and 191) and a lowered threshold, so the minimum crosses the threshold every few steps across the whole frame, tail steps included. The bench judges the result by decoded bytes that must equal the encoded data exactly. An assertion checks that every renormalising step lowers the minimum and that no metric nears the top of its range.

// File: rtl/vit_pkg.sv
package vit_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RUN,
    PH_TRACE,
    PH_EMIT,
    PH_DONE
  } vit_phase_e;

  // parity of a tap-masked encoder register
  function automatic logic tap_parity(input logic [15:0] masked);
    return ^masked;
  endfunction

  // distance of one soft symbol from the ideal level of the expected bit
  function automatic logic [8:0] soft_dist(input logic exp_bit, input logic [7:0] rx);
    return exp_bit ? {1'b0, 8'hFF - rx} : {1'b0, rx};
  endfunction

  // branch metric of one symbol pair
  function automatic logic [9:0] pair_metric(input logic ea, input logic eb,
                                             input logic [7:0] ra, input logic [7:0] rb);
    return {1'b0, soft_dist(ea, ra)} + {1'b0, soft_dist(eb, rb)};
  endfunction

endpackage

// File: rtl/vit_acs_array.sv
module vit_acs_array #(
  parameter int SW        = 6,
  parameter int PM_W      = 16,
  parameter int INIT_BIAS = 1024,
  parameter int RENORM_TH = 16384,
  parameter int POLY_A    = 'h6D,
  parameter int POLY_B    = 'h4F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [SW-1:0]     start_state,
  input  logic              step,
  input  logic [7:0]        sym_a,
  input  logic [7:0]        sym_b,
  input  logic              inv_a,
  input  logic              inv_b,
  output logic [(1<<SW)-1:0] dec_row
);
  import vit_pkg::*;

  localparam int NS = 1 << SW;
  localparam int OVF_MARK = (1 << PM_W) - 1024;

  logic [PM_W-1:0] pm     [NS];
  logic [PM_W-1:0] pm_nxt [NS];
  logic [PM_W-1:0] pm_min;
  logic [PM_W-1:0] pm_sub;
  logic            renorm_hit;
  logic            pm_ovf_risk;

  always_comb begin
    pm_min = pm[0];
    for (int i = 1; i < NS; i++)
      if (pm[i] < pm_min) pm_min = pm[i];
  end

  always_comb begin
    pm_ovf_risk = 1'b0;
    for (int i = 0; i < NS; i++)
      if (32'(pm[i]) >= OVF_MARK) pm_ovf_risk = 1'b1;
  end

  assign renorm_hit = (32'(pm_min) >= RENORM_TH);
  assign pm_sub     = renorm_hit ? pm_min : '0;

  for (genvar g = 0; g < NS; g++) begin : g_state
    localparam int P0 = g >> 1;
    localparam int P1 = (g >> 1) | (NS / 2);
    localparam logic EA0 = tap_parity(16'(g & POLY_A));
    localparam logic EA1 = tap_parity(16'((g | NS) & POLY_A));
    localparam logic EB0 = tap_parity(16'(g & POLY_B));
    localparam logic EB1 = tap_parity(16'((g | NS) & POLY_B));
    logic [9:0]      bm0, bm1;
    logic [PM_W-1:0] cand0, cand1;
    assign bm0   = pair_metric(EA0 ^ inv_a, EB0 ^ inv_b, sym_a, sym_b);
    assign bm1   = pair_metric(EA1 ^ inv_a, EB1 ^ inv_b, sym_a, sym_b);
    assign cand0 = pm[P0] + PM_W'(bm0);
    assign cand1 = pm[P1] + PM_W'(bm1);
    assign dec_row[g] = (cand1 < cand0);
    assign pm_nxt[g]  = (dec_row[g] ? cand1 : cand0) - pm_sub;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) pm[i] <= '0;
    end else if (init) begin
      for (int i = 0; i < NS; i++)
        pm[i] <= (i == int'(start_state)) ? '0 : PM_W'(INIT_BIAS);
    end else if (step) begin
      for (int i = 0; i < NS; i++) pm[i] <= pm_nxt[i];
    end
  end

  // R8
  renorm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !init && renorm_hit) |=> (pm_min < $past(pm_min)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_ovf_risk);

endmodule

// File: rtl/vit_survivor_mem.sv
module vit_survivor_mem #(
  parameter int NS    = 64,
  parameter int DEPTH = 262,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [NS-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [NS-1:0] rdata
);
  logic [NS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/vit_traceback.sv
module vit_traceback #(
  parameter int SW       = 6,
  parameter int MAX_BITS = 256,
  parameter int LEN_W    = 16,
  parameter int AW       = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 en,
  input  logic [SW-1:0]        end_state,
  input  logic [AW-1:0]        last_step,
  input  logic [LEN_W-1:0]     len,
  input  logic [(1<<SW)-1:0]   row,
  output logic [AW-1:0]        raddr,
  output logic                 last,
  output logic [MAX_BITS-1:0]  bits
);
  logic [SW-1:0] tb_state;
  logic [AW-1:0] tb_step;
  logic          surv;

  assign raddr = tb_step;
  assign last  = (tb_step == '0);
  assign surv  = row[tb_state];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_state <= '0;
      tb_step  <= '0;
      bits     <= '0;
    end else if (load) begin
      tb_state <= end_state;
      tb_step  <= last_step;
    end else if (en) begin
      for (int j = 0; j < MAX_BITS; j++)
        if (tb_step == AW'(j) && LEN_W'(j) < len) bits[j] <= tb_state[0];
      tb_state <= {surv, tb_state[SW-1:1]};
      if (!last) tb_step <= tb_step - 1'b1;
    end
  end

endmodule

// File: rtl/vit_byte_packer.sv
module vit_byte_packer #(
  parameter int MAX_BITS = 256,
  parameter int LEN_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                en,
  input  logic [LEN_W-1:0]    len,
  input  logic [MAX_BITS-1:0] bits,
  output logic [7:0]          byte_out,
  output logic                last
);
  logic [LEN_W-1:0]   byte_idx;
  logic [LEN_W+2:0]   base;
  logic [LEN_W:0]     nbytes;
  logic [MAX_BITS-1:0] shifted;

  assign base    = {byte_idx, 3'b000};
  assign shifted = bits >> base;
  assign nbytes  = ({1'b0, len} + (LEN_W+1)'(7)) >> 3;
  assign last    = (({1'b0, byte_idx} + 1'b1) == nbytes);

  always_comb begin
    for (int k = 0; k < 8; k++)
      byte_out[7-k] = shifted[k] && ((base + (LEN_W+3)'(k)) < {3'b000, len});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     byte_idx <= '0;
    else if (clear) byte_idx <= '0;
    else if (en)    byte_idx <= byte_idx + 1'b1;
  end

endmodule

// File: rtl/vit_decoder.sv
module vit_decoder #(
  parameter int MAX_BITS  = 256,
  parameter int LEN_W     = 16,
  parameter int PM_W      = 16,
  parameter int INIT_BIAS = 1024,
  parameter int RENORM_TH = 16384,
  parameter int POLY_A    = 'h6D,
  parameter int POLY_B    = 'h4F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [5:0]       start_state,
  input  logic [5:0]       end_state,
  input  logic [2:0]       conv,
  input  logic             sym_valid,
  input  logic [15:0]      sym_pair,
  output logic             sym_ready,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             done,
  output logic             err
);
  import vit_pkg::*;

  localparam int SW    = 6;
  localparam int NS    = 1 << SW;
  localparam int TAIL  = SW;
  localparam int DEPTH = MAX_BITS + TAIL;
  localparam int AW    = $clog2(DEPTH);

  vit_phase_e        st;
  logic [LEN_W-1:0]  len_q;
  logic [SW-1:0]     es_q;
  logic [2:0]        conv_q;
  logic [AW-1:0]     step_cnt;
  logic              err_q;

  logic              len_ok, sym_fire, frame_end, acs_init;
  logic [AW-1:0]     last_step;
  logic [7:0]        sym_a, sym_b;
  logic [NS-1:0]     dec_row, rd_row;
  logic [AW-1:0]     tb_raddr;
  logic              tb_en, tb_last, pk_clear, pk_en, pk_last;
  logic [MAX_BITS-1:0] tb_bits;
  logic [7:0]        pk_byte;

  assign len_ok    = (len != '0) && (len <= LEN_W'(MAX_BITS));
  assign sym_ready = (st == PH_RUN);
  assign sym_fire  = sym_valid && sym_ready;
  assign last_step = AW'(len_q + LEN_W'(TAIL - 1));
  assign frame_end = sym_fire && (step_cnt == last_step);
  assign acs_init  = (st == PH_IDLE) && start && len_ok;
  assign sym_a     = conv_q[2] ? sym_pair[15:8] : sym_pair[7:0];
  assign sym_b     = conv_q[2] ? sym_pair[7:0]  : sym_pair[15:8];
  assign tb_en     = (st == PH_TRACE);
  assign pk_clear  = tb_en && tb_last;
  assign pk_en     = (st == PH_EMIT);

  assign out_valid = pk_en;
  assign out_byte  = pk_en ? pk_byte : 8'h00;
  assign done      = (st == PH_DONE);
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PH_IDLE;
      len_q    <= '0;
      es_q     <= '0;
      conv_q   <= '0;
      step_cnt <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        PH_IDLE: if (start) begin
          if (len_ok) begin
            len_q    <= len;
            es_q     <= end_state;
            conv_q   <= conv;
            step_cnt <= '0;
            st       <= PH_RUN;
          end else begin
            err_q <= 1'b1;
          end
        end
        PH_RUN: if (sym_fire) begin
          step_cnt <= step_cnt + 1'b1;
          if (frame_end) st <= PH_TRACE;
        end
        PH_TRACE: if (tb_last) st <= PH_EMIT;
        PH_EMIT:  if (pk_last) st <= PH_DONE;
        PH_DONE:  st <= PH_IDLE;
        default:  st <= PH_IDLE;
      endcase
    end
  end

  vit_acs_array #(
    .SW(SW), .PM_W(PM_W), .INIT_BIAS(INIT_BIAS), .RENORM_TH(RENORM_TH),
    .POLY_A(POLY_A), .POLY_B(POLY_B)
  ) u_acs (
    .clk(clk), .rst_n(rst_n), .init(acs_init), .start_state(start_state),
    .step(sym_fire), .sym_a(sym_a), .sym_b(sym_b),
    .inv_a(conv_q[0]), .inv_b(conv_q[1]), .dec_row(dec_row)
  );

  vit_survivor_mem #(.NS(NS), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(sym_fire), .waddr(step_cnt), .wdata(dec_row),
    .raddr(tb_raddr), .rdata(rd_row)
  );

  vit_traceback #(.SW(SW), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .AW(AW)) u_tb (
    .clk(clk), .rst_n(rst_n), .load(frame_end), .en(tb_en),
    .end_state(es_q), .last_step(last_step), .len(len_q), .row(rd_row),
    .raddr(tb_raddr), .last(tb_last), .bits(tb_bits)
  );

  vit_byte_packer #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(pk_clear), .en(pk_en),
    .len(len_q), .bits(tb_bits), .byte_out(pk_byte), .last(pk_last)
  );

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!sym_ready && !out_valid && !done));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !sym_ready);

  // R9
  done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid));

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && out_valid));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != PH_IDLE) |=> $stable(len_q));

endmodule

// File: tb/tb_vit_decoder.sv
module tb_vit_decoder;

  typedef struct packed {
    logic [7:0]  len;
    logic [5:0]  ss;
    logic [5:0]  es;
    logic [2:0]  conv;
    logic [1:0]  noise;   // 0 clean, 1 two flipped symbols, 2 weak levels
    logic [63:0] data;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd8,  6'd0,  6'd0,  3'd0, 2'd0, 64'h00000000000000A5}, // R1
    '{8'd16, 6'd0,  6'd0,  3'd0, 2'd1, 64'h0000000000003C5A}, // R11
    '{8'd13, 6'd0,  6'd0,  3'd1, 2'd0, 64'h0000000000001B6D}, // R5 R6
    '{8'd24, 6'd5,  6'h2A, 3'd3, 2'd0, 64'h0000000000C3E1F0}, // R3 R4
    '{8'd20, 6'd0,  6'h3F, 3'd4, 2'd1, 64'h00000000000A5F3C}, // R6 R11
    '{8'd64, 6'h11, 6'd0,  3'd6, 2'd2, 64'hDEADBEEF0123A5C7}, // R8
    '{8'd1,  6'd0,  6'd0,  3'd0, 2'd0, 64'h0000000000000001}, // R5
    '{8'd40, 6'd0,  6'd9,  3'd5, 2'd2, 64'h0000009A7C3E5D1B}  // R8 R6
  };
  localparam string TAGS [NV] = '{"R1","R11","R5","R3","R6","R8","R5","R8"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] len = '0;
  logic [5:0]  start_state = '0, end_state = '0;
  logic [2:0]  conv = '0;
  logic        sym_valid = 1'b0;
  logic [15:0] sym_pair = '0;
  logic        sym_ready, out_valid, done, err;
  logic [7:0]  out_byte;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vit_decoder #(.MAX_BITS(64), .RENORM_TH(1024)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .start_state(start_state), .end_state(end_state), .conv(conv),
    .sym_valid(sym_valid), .sym_pair(sym_pair), .sym_ready(sym_ready),
    .out_valid(out_valid), .out_byte(out_byte), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int ones_parity(input int v, input int poly);
    int n = 0;
    for (int i = 0; i < 7; i++)
      if (((v >> i) & 1) == 1 && ((poly >> i) & 1) == 1) n++;
    return n % 2;
  endfunction

  task automatic run_frame(input vec_t v, input string tag, input bit poke);
    logic [7:0] got [16];
    int nb = 0, sr, nbytes;
    bit prev_v = 0, seen_done = 0;
    @(negedge clk);
    start = 1; len = 16'(v.len); start_state = v.ss; end_state = v.es; conv = v.conv;
    @(negedge clk);
    start = 0;
    sr = int'(v.ss);
    for (int i = 0; i < int'(v.len) + 6; i++) begin
      int b, r7, ea, eb, sa, sb;
      b  = (i < int'(v.len)) ? int'(v.data[i]) : int'(v.es[5 - (i - int'(v.len))]);
      r7 = (sr << 1) | b;
      ea = ones_parity(r7, 'h6D) ^ int'(v.conv[0]);
      eb = ones_parity(r7, 'h4F) ^ int'(v.conv[1]);
      sa = (v.noise == 2) ? (ea == 1 ? 191 : 64) : (ea == 1 ? 255 : 0);
      sb = (v.noise == 2) ? (eb == 1 ? 191 : 64) : (eb == 1 ? 255 : 0);
      if (v.noise == 1 && i == 2)  sa = 255 - sa;
      if (v.noise == 1 && i == 12) sb = 255 - sb;
      sr = r7 & 63;
      while (!sym_ready) @(negedge clk);
      sym_valid = 1;
      sym_pair  = v.conv[2] ? {8'(sa), 8'(sb)} : {8'(sb), 8'(sa)};
      if (poke && i == 3) begin start = 1; len = 16'd5; conv = 3'd0; end // R10
      @(negedge clk);
      start = 0;
    end
    sym_valid = 0;
    chk(!sym_ready, "R2", "ready after len+6 pairs", sym_ready, 0);
    for (int c = 0; c < 400 && !seen_done; c++) begin
      if (done) begin
        seen_done = 1;
        chk(prev_v, "R9", "done follows last byte", prev_v, 1);
        chk(!out_valid, "R9", "valid with done", out_valid, 0);
      end
      if (out_valid) begin
        if (nb < 16) got[nb] = out_byte;
        nb++;
      end
      prev_v = out_valid;
      if (!seen_done) @(negedge clk);
    end
    chk(seen_done, "R9", "done seen", seen_done, 1);
    nbytes = (int'(v.len) + 7) / 8;
    chk(nb == nbytes, "R4", "byte count", nb, nbytes);
    for (int k = 0; k < nbytes && k < nb; k++) begin
      logic [7:0] e;
      for (int p = 0; p < 8; p++)
        e[7-p] = (8*k + p < int'(v.len)) ? v.data[8*k + p] : 1'b0;
      chk(got[k] == e, poke ? "R10" : tag, $sformatf("byte %0d", k), got[k], e);
    end
  endtask

  task automatic bad_start(input int l);
    @(negedge clk);
    start = 1; len = 16'(l);
    @(negedge clk);
    start = 0;
    chk(err == 1, "R7", $sformatf("err for len %0d", l), err, 1);
    chk(!sym_ready, "R7", "no ready on reject", sym_ready, 0);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(!err && !sym_ready && !out_valid && !done, "R7", "quiet after reject",
          {err, sym_ready, out_valid, done}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!sym_ready && !out_valid && !done && !err, "R2", "reset outputs",
        {sym_ready, out_valid, done, err}, 0);
    for (int n = 0; n < NV; n++) run_frame(VECS[n], TAGS[n], 1'b0);
    run_frame(VECS[3], "R10", 1'b1);
    bad_start(65);
    bad_start(0);
    run_frame(VECS[0], "R7", 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule